// File: doc/BRIEF.md
# Rotating Four-Cell Self-Test Tile

The tile holds four identical lookup-table cells, numbered 0 to 3 (cells A to D). All four are loaded with one common function, and each cell has a fault input that inverts its output. A test run has four sessions. In each session a fixed schedule gives every cell one role. One cell is the pattern source and supplies an exhaustive up-count over the LUT address space. Two cells are under test and are fed that count. The fourth cell is the comparator: it keeps a sticky fail bit that is set whenever the two tested outputs differ.

Roles move from cell to cell across the sessions, so the four pass/fail results form a syndrome that points to a single faulty cell. A cell that fails while it is the pattern source still produces the full count, so its session passes. A faulty comparator always reports fail. A faulty cell under test always mismatches its partner. Each cell is the pattern source in exactly one session, so a lone faulty cell leaves exactly one passing session, and the index of that session is the cell's index. The decoder reports a location only for such a syndrome.

The control is one state machine. Its states are IDLE, CLEAR, APPLY, LATCH and DONE. The transitions are:
- IDLE goes to CLEAR on start, and clears the syndrome and the session index.
- CLEAR goes to APPLY, and resets the vector count and the sticky bit.
- APPLY stays in APPLY for 2^LUT_K cycles, then goes to LATCH.
- LATCH stores the sticky bit. It goes back to CLEAR for the next session, or to DONE after the last session.
- DONE raises done for one cycle and returns to IDLE.

Top module: `rotating_selftest_tile`

## Requirements
- R1: After reset, done is 0, syndrome is 0 and fault_valid is 0.
- R2: A run starts when start is sampled high in IDLE. done is high for exactly one cycle, 4*(2^LUT_K+2) clock edges after the start edge.
- R3: Session schedule, written as (pattern source, comparator, pair under test): session 0 = (0, 1, {2,3}); session 1 = (1, 0, {2,3}); session 2 = (2, 3, {0,1}); session 3 = (3, 2, {0,1}).
- R4: syndrome bit s is 1 (fail) exactly when the comparator cell of session s is faulty, or when exactly one of the two cells under test is faulty. A faulty pattern source on its own never causes a fail.
- R5: With no fault input set, syndrome is 0 and fault_valid is 0. This holds for any loaded function.
- R6: fault_valid is 1 exactly when syndrome holds exactly one 0 bit. fault_id is then the index of that bit (0=A, 1=B, 2=C, 3=D). For a single faulty cell k, syndrome is all ones except bit k.
- R7: start is ignored while a run is in progress. The run ends at the R2 time and gives the R4 syndrome.
- R8: Between runs, syndrome, fault_valid and fault_id hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a four-session run when idle |
| cell_func | input | 2^LUT_K | Truth table loaded into all four cells |
| fault_inj | input | 4 | Per-cell output inversion, bit k for cell k |
| done | output | 1 | One-cycle pulse when the run completes |
| syndrome | output | 4 | Per-session result, 1 = fail |
| fault_valid | output | 1 | Syndrome points to exactly one cell |
| fault_id | output | 2 | Index of the located cell |

## Verification
The bench builds the tile with the default LUT_K of 4. This gives sessions of 16 vectors, so a full run takes 72 edges and many runs fit in a short simulation. The bench runs all sixteen fault masks under five truth tables, including all-zero and all-one. This covers every single fault, the multi-fault syndromes that look like a single fault, and the all-pass syndrome. Separate runs check that start is ignored in mid-run and that the results are held while the tile is idle.

// File: rtl/tile_pkg.sv
package tile_pkg;

    localparam int CELLS    = 4;
    localparam int SESSIONS = 4;
    localparam int ID_W     = $clog2(CELLS);
    localparam int SESS_W   = $clog2(SESSIONS);

    typedef enum logic [1:0] {
        ROLE_SRC = 2'd0,
        ROLE_DUT = 2'd1,
        ROLE_CMP = 2'd2
    } role_e;

    // Role of cell c in session s.
    function automatic role_e role_of(input int s, input int c);
        role_e r;
        r = ROLE_DUT;
        if (c == s) begin
            r = ROLE_SRC;
        end else begin
            case (s)
                0: if (c == 1) r = ROLE_CMP;
                1: if (c == 0) r = ROLE_CMP;
                2: if (c == 3) r = ROLE_CMP;
                default: if (c == 2) r = ROLE_CMP;
            endcase
        end
        return r;
    endfunction

    // Syndrome a lone faulty cell c produces: fail in every session where it is not the source.
    function automatic logic [SESSIONS-1:0] lone_fault_pattern(input int c);
        logic [SESSIONS-1:0] p;
        for (int s = 0; s < SESSIONS; s++) begin
            p[s] = (role_of(s, c) != ROLE_SRC);
        end
        return p;
    endfunction

endpackage

// File: rtl/lut_cell.sv
module lut_cell #(
    parameter int LUT_K = 4
) (
    input  logic [(1<<LUT_K)-1:0] func,
    input  logic [LUT_K-1:0]      addr,
    input  logic                  fault,
    output logic                  y
);
    always_comb begin
        y = func[addr] ^ fault;
    end
endmodule

// File: rtl/session_seq.sv
module session_seq
    import tile_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mismatch,
    output logic [LUT_K-1:0]    vec,
    output logic [SESS_W-1:0]   sess,
    output logic [SESSIONS-1:0] syndrome,
    output logic                done,
    output logic                busy
);
    localparam logic [LUT_K-1:0]  VEC_LAST  = '1;
    localparam logic [SESS_W-1:0] SESS_LAST = SESS_W'(SESSIONS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_APPLY,
        ST_LATCH,
        ST_DONE
    } state_e;

    state_e state, state_nx;
    logic   sticky;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CLEAR;
            ST_CLEAR: state_nx = ST_APPLY;
            ST_APPLY: if (vec == VEC_LAST) state_nx = ST_LATCH;
            ST_LATCH: state_nx = (sess == SESS_LAST) ? ST_DONE : ST_CLEAR;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec      <= '0;
            sess     <= '0;
            sticky   <= 1'b0;
            syndrome <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        syndrome <= '0;
                        sess     <= '0;
                    end
                end
                ST_CLEAR: begin
                    vec    <= '0;
                    sticky <= 1'b0;
                end
                ST_APPLY: begin
                    sticky <= sticky | mismatch;
                    vec    <= vec + 1'b1;
                end
                ST_LATCH: begin
                    syndrome[sess] <= sticky;
                    sess           <= sess + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        done = (state == ST_DONE);
        busy = (state != ST_IDLE);
    end
endmodule

// File: rtl/syndrome_decoder.sv
module syndrome_decoder
    import tile_pkg::*;
(
    input  logic [SESSIONS-1:0] syndrome,
    output logic                fault_valid,
    output logic [ID_W-1:0]     fault_id
);
    logic [CELLS-1:0] match;

    for (genvar c = 0; c < CELLS; c++) begin : g_match
        assign match[c] = (syndrome == lone_fault_pattern(c));
    end

    always_comb begin
        fault_valid = |match;
        fault_id    = '0;
        for (int c = 0; c < CELLS; c++) begin
            if (match[c]) fault_id = ID_W'(c);
        end
    end
endmodule

// File: rtl/rotating_selftest_tile.sv
module rotating_selftest_tile
    import tile_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [(1<<LUT_K)-1:0] cell_func,
    input  logic [3:0]            fault_inj,
    output logic                  done,
    output logic [3:0]            syndrome,
    output logic                  fault_valid,
    output logic [1:0]            fault_id
);
    logic [LUT_K-1:0]  vec;
    logic [SESS_W-1:0] sess;
    logic [CELLS-1:0]  cell_y;
    logic              mismatch;
    logic              busy;

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        lut_cell #(.LUT_K(LUT_K)) cell_i (
            .func  (cell_func),
            .addr  (vec),
            .fault (fault_inj[c]),
            .y     (cell_y[c])
        );
    end

    // Route outputs by role: XOR of the pair under test, and a forced fail from a bad comparator.
    always_comb begin
        logic dut_x;
        logic cmp_bad;
        dut_x   = 1'b0;
        cmp_bad = 1'b0;
        for (int c = 0; c < CELLS; c++) begin
            if (role_of(int'(sess), c) == ROLE_DUT) dut_x   = dut_x ^ cell_y[c];
            if (role_of(int'(sess), c) == ROLE_CMP) cmp_bad = cmp_bad | fault_inj[c];
        end
        mismatch = dut_x | cmp_bad;
    end

    session_seq #(.LUT_K(LUT_K)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mismatch (mismatch),
        .vec      (vec),
        .sess     (sess),
        .syndrome (syndrome),
        .done     (done),
        .busy     (busy)
    );

    syndrome_decoder dec_i (
        .syndrome    (syndrome),
        .fault_valid (fault_valid),
        .fault_id    (fault_id)
    );
endmodule

// File: rtl/selftest_checker.sv
module selftest_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       done,
    input logic [3:0] syndrome,
    input logic       fault_valid,
    input logic [1:0] fault_id,
    input logic       busy
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_ALLPASS_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome == 4'b0000) |-> !fault_valid); // R5

    AST_VALID_ONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ($countones(syndrome) == 3 && !syndrome[fault_id])); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (syndrome == 4'b0000)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(syndrome) && $stable(fault_valid))); // R8
endmodule

bind rotating_selftest_tile selftest_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .syndrome    (syndrome),
    .fault_valid (fault_valid),
    .fault_id    (fault_id),
    .busy        (busy)
);

// File: tb/rotating_selftest_tile_tb.sv
module rotating_selftest_tile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LUT_K      = 4;
    localparam int RUN_EDGES  = 4 * ((1 << LUT_K) + 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cell_func = 16'h0;
    logic [3:0]  fault_inj = 4'h0;
    logic        done;
    logic [3:0]  syndrome;
    logic        fault_valid;
    logic [1:0]  fault_id;

    int total = 0;
    int bad   = 0;

    int src_of [4] = '{0, 1, 2, 3};
    int cmp_of [4] = '{1, 0, 3, 2};

    rotating_selftest_tile #(.LUT_K(LUT_K)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cell_func   (cell_func),
        .fault_inj   (fault_inj),
        .done        (done),
        .syndrome    (syndrome),
        .fault_valid (fault_valid),
        .fault_id    (fault_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_synd(input logic [3:0] f);
        logic [3:0] s;
        for (int k = 0; k < 4; k++) begin
            logic dx;
            dx = 1'b0;
            for (int c = 0; c < 4; c++)
                if (c != src_of[k] && c != cmp_of[k]) dx = dx ^ f[c];
            s[k] = f[cmp_of[k]] | dx;
        end
        return s;
    endfunction

    // Start a run. Optionally pulse start again mid-run. Returns edges from start to done.
    task automatic do_run(input logic [15:0] fn, input logic [3:0] f,
                          input bit poke, output int edges);
        cell_func = fn;
        fault_inj = f;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        while (edges < 400) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (poke) start = (edges == 20 || edges == 40);
            if (done) break;
        end
        start = 1'b0;
    endtask

    task automatic check_result(input logic [3:0] f);
        logic [3:0] es;
        int ones, zid;
        es = model_synd(f);
        ones = 0;
        zid = 0;
        for (int k = 0; k < 4; k++) begin
            if (es[k]) ones++;
            else zid = k;
        end
        check("R4 syndrome", int'(syndrome), int'(es));
        if (f == 4'h0) check("R5 fault-free syndrome", int'(syndrome), 0);
        check("R6 fault_valid", int'(fault_valid), (ones == 3) ? 1 : 0);
        if (ones == 3) check("R6 fault_id", int'(fault_id), zid);
        if (f == 4'b0001 || f == 4'b0010 || f == 4'b0100 || f == 4'b1000)
            check("R6 lone fault located", int'(fault_id), $clog2(int'(f)));
    endtask

    initial begin
        logic [15:0] funcs [5] = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h6996, 16'h1234};
        int edges;
        repeat (3) @(negedge clk);
        check("R1 done", int'(done), 0);
        check("R1 syndrome", int'(syndrome), 0);
        check("R1 fault_valid", int'(fault_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep over all fault masks and several truth tables (R3, R4, R5, R6).
        for (int fi = 0; fi < 5; fi++) begin
            for (int m = 0; m < 16; m++) begin
                do_run(funcs[fi], 4'(m), 1'b0, edges);
                check("R2 latency", edges, RUN_EDGES);
                check_result(4'(m));
                @(negedge clk);
                check("R2 done single cycle", int'(done), 0);
            end
        end

        // R7: start pulses in mid-run are ignored.
        do_run(16'hC3C3, 4'b0100, 1'b1, edges);
        check("R7 latency with mid-run start", edges, RUN_EDGES);
        check_result(4'b0100);

        // R8: results held while idle, even after the inputs change.
        fault_inj = 4'b0000;
        cell_func = 16'h0F0F;
        repeat (10) @(negedge clk);
        check("R8 syndrome held", int'(syndrome), int'(model_synd(4'b0100)));
        check("R8 fault_valid held", int'(fault_valid), 1);
        check("R8 fault_id held", int'(fault_id), 2);
        check("R8 done low", int'(done), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule